// File: doc/BRIEF.md
# Byte-Wide Strobe Bus to 32-bit Register Bridge

This block is a slave on a slow peripheral bus that runs from no shared clock. The bus has a select, a read strobe, a write strobe, a three-bit address, an input byte, an output byte with its own enable, and a ready line. Every register behind the bridge is 32 bits wide. The bridge therefore splits a register into bytes on a read and gathers bytes into a register on a write. It resynchronises the strobes into the system clock. It drives ready once an access has taken effect.

The bus has two windows. One is a byte-wide register index. The other is a four-lane data window onto the register that the index names. The bridge holds five registers of its own: an identity word, a reset-control word, a performance-control word and two performance counters. Any other index goes out on a simple register port to registers that live in other blocks.

Identity word layout, most significant first: a 16-bit manufacturer code in [31:16], an 8-bit implementation number in [15:8], a 4-bit version in [7:4], and the count of ports supported in [3:0].

Top module: `ebb_byte_bridge`

## Requirements
- R1: After reset, `hb_rdy`, `hb_oe`, `rp_we` and `rst_ctrl` are all zero, and the register index reads back as 0.
- R2: With select and one strobe held steady, `hb_rdy` rises on the 4th rising clock edge after the strobe is applied. It then stays high until the strobe is removed, and falls on the 3rd rising edge after removal.
- R3: Address bit 2 low selects the index window. A write there stores the byte as the register index, and a read there returns the index.
- R4: Address bit 2 high selects the data window, with the byte lane in bits [1:0] (lane 0 is the least significant byte). Writes to lanes 0, 1 and 2 only stage their bytes. A write to lane 3 commits {lane3, lane2, lane1, lane0} to the indexed register in one step.
- R5: A data-window read of lane 0 captures the whole indexed register and returns its bytes [7:0]. Reads of lanes 1 to 3 return bytes of that capture, even if the register changed after it.
- R6: Index 0 reads as the identity word {code[15:0], impl[7:0], version[3:0], ports[3:0]}, taken from parameters.
- R7: Index 1 is the reset-control register. It is read/write, and its value appears at all times on `rst_ctrl`.
- R8: Index 2 is the performance-control register. Bits [2:0] select the event and bit 7 enables counter 0; bits [10:8] select the event and bit 15 enables counter 1. Indices 3 and 4 are the counters. Each counter adds one on every clock in which it is enabled and its selected `evt` bit is high, and a commit loads it.
- R9: For an index of 5 or more, a commit gives a single one-clock `rp_we` pulse with `rp_idx` equal to the index and `rp_wdata` equal to the word. Reads of such an index return `rp_rdata`.
- R10: Writes to index 0 change nothing: the identity word reads back unchanged and no `rp_we` pulse appears.
- R11: `hb_oe` is high only while select and the read strobe are both high; a write never enables the output.
- R12: A strobe that is held performs exactly one access, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Bus select, active high |
| hb_rd | input | 1 | Read strobe, active high |
| hb_wr | input | 1 | Write strobe, active high |
| hb_addr | input | 3 | Window (bit 2) and byte lane (bits 1:0) |
| hb_din | input | 8 | Write byte from the bus |
| hb_dout | output | 8 | Read byte to the bus |
| hb_oe | output | 1 | Output enable for `hb_dout` |
| hb_rdy | output | 1 | Access complete |
| rst_ctrl | output | 32 | Reset-control register contents |
| evt | input | NEV | Event inputs for the performance counters |
| rp_idx | output | 8 | Register index for external registers |
| rp_we | output | 1 | One-clock write pulse for external registers |
| rp_wdata | output | 32 | Write word for external registers |
| rp_rdata | input | 32 | Read word from external registers |

## Verification
The assertions assume that the bus controller holds address and write data steady from before a strobe until after ready. They also assume that it never raises both strobes at once, and that it does not start a new strobe while ready is still high. Under those conditions, a change of `rst_ctrl` can be traced back to a lane-3 write held one edge earlier, and ready can be traced back to a strobe applied three edges earlier. The bench keeps within these limits. Every bus signal changes on the falling clock edge inside one task. Each access waits for ready to rise and then fall before the task returns. The `evt` inputs are driven only between accesses.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_HOLD = 2'd1,
    HS_RDY  = 2'd2
  } hs_state_e;

  localparam int          IDX_W    = 8;
  localparam logic [7:0]  IDX_ID   = 8'd0;
  localparam logic [7:0]  IDX_RSTC = 8'd1;
  localparam logic [7:0]  IDX_PCTL = 8'd2;
  localparam logic [7:0]  IDX_PC0  = 8'd3;
  localparam logic [7:0]  N_LOCAL  = 8'd5;
endpackage

// File: rtl/ebb_sync_edge.sv
module ebb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ebb_perf_ctr.sv
module ebb_perf_ctr #(
  parameter int W    = 32,
  parameter int NEV  = 8,
  parameter int SELW = $clog2(NEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] sel,
  input  logic [NEV-1:0]  events,
  input  logic            ld,
  input  logic [W-1:0]    ld_val,
  output logic [W-1:0]    cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt;
    if (ld) begin
      cnt_ce = 1'b1;
      cnt_d  = ld_val;
    end else if (en && events[sel]) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end
endmodule

// File: rtl/ebb_byte_bridge.sv
module ebb_byte_bridge
  import ebb_pkg::*;
#(
  parameter int          NEV    = 8,
  parameter logic [15:0] ID_CODE = 16'h1F3A,
  parameter logic [7:0]  ID_IMPL = 8'h21,
  parameter logic [3:0]  ID_VER  = 4'h2,
  parameter logic [3:0]  ID_PRTS = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_rd,
  input  logic              hb_wr,
  input  logic [2:0]        hb_addr,
  input  logic [7:0]        hb_din,
  output logic [7:0]        hb_dout,
  output logic              hb_oe,
  output logic              hb_rdy,
  output logic [31:0]       rst_ctrl,
  input  logic [NEV-1:0]    evt,
  output logic [IDX_W-1:0]  rp_idx,
  output logic              rp_we,
  output logic [31:0]       rp_wdata,
  input  logic [31:0]       rp_rdata
);
  localparam int SELW  = $clog2(NEV);
  localparam int NCTR  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  logic rd_lvl, rd_rise, wr_lvl, wr_rise;
  ebb_sync_edge #(.STAGES(2)) u_rd_sync (
    .clk(clk), .rst_n(rst_q_n), .async_i(hb_sel & hb_rd),
    .level_o(rd_lvl), .rise_o(rd_rise));
  ebb_sync_edge #(.STAGES(2)) u_wr_sync (
    .clk(clk), .rst_n(rst_q_n), .async_i(hb_sel & hb_wr),
    .level_o(wr_lvl), .rise_o(wr_rise));

  hs_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [23:0]       stage_q, stage_d;
  logic [31:0]       snap_q, snap_d;
  logic [7:0]        dout_q, dout_d;
  logic [31:0]       rstc_q, pctl_q;
  logic              rp_we_q;
  logic [31:0]       rp_wdata_q;
  logic [31:0]       cnt [NCTR];
  logic [31:0]       cur_word, commit_word;
  logic              go_rd, go_wr, commit, win;
  logic [1:0]        lane;

  assign win         = hb_addr[2];
  assign lane        = hb_addr[1:0];
  assign go_rd       = (st_q == HS_IDLE) && rd_rise;
  assign go_wr       = (st_q == HS_IDLE) && wr_rise && !rd_rise;
  assign commit      = go_wr && win && (lane == 2'd3);
  assign commit_word = {hb_din, stage_q};

  always_comb begin
    case (idx_q)
      IDX_ID:   cur_word = {ID_CODE, ID_IMPL, ID_VER, ID_PRTS};
      IDX_RSTC: cur_word = rstc_q;
      IDX_PCTL: cur_word = pctl_q;
      IDX_PC0:  cur_word = cnt[0];
      IDX_PC0 + 8'd1: cur_word = cnt[1];
      default:  cur_word = rp_rdata;
    endcase
  end

  // handshake sequencing
  always_comb begin
    st_d = st_q;
    case (st_q)
      HS_IDLE: if (go_rd || go_wr)     st_d = HS_HOLD;
      HS_HOLD:                         st_d = HS_RDY;
      HS_RDY:  if (!rd_lvl && !wr_lvl) st_d = HS_IDLE;
      default:                         st_d = HS_IDLE;
    endcase
  end

  // byte steering
  always_comb begin
    idx_d   = idx_q;
    stage_d = stage_q;
    snap_d  = snap_q;
    dout_d  = dout_q;
    if (go_wr) begin
      if (!win) idx_d = hb_din;
      else begin
        case (lane)
          2'd0:    stage_d[7:0]   = hb_din;
          2'd1:    stage_d[15:8]  = hb_din;
          2'd2:    stage_d[23:16] = hb_din;
          default: stage_d        = stage_q;
        endcase
      end
    end
    if (go_rd) begin
      if (!win)              dout_d = idx_q;
      else if (lane == 2'd0) begin
        snap_d = cur_word;
        dout_d = cur_word[7:0];
      end else               dout_d = snap_q[{lane, 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q       <= HS_IDLE;
      idx_q      <= '0;
      stage_q    <= '0;
      snap_q     <= '0;
      dout_q     <= '0;
      rstc_q     <= '0;
      pctl_q     <= '0;
      rp_we_q    <= 1'b0;
      rp_wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      stage_q <= stage_d;
      snap_q  <= snap_d;
      dout_q  <= dout_d;
      rp_we_q <= commit && (idx_q >= N_LOCAL);
      if (commit && idx_q == IDX_RSTC) rstc_q     <= commit_word;
      if (commit && idx_q == IDX_PCTL) pctl_q     <= commit_word;
      if (commit)                      rp_wdata_q <= commit_word;
    end
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    ebb_perf_ctr #(.W(32), .NEV(NEV), .SELW(SELW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .en     (pctl_q[8*i+7]),
      .sel    (pctl_q[8*i +: SELW]),
      .events (evt),
      .ld     (commit && (idx_q == IDX_PC0 + 8'(i))),
      .ld_val (commit_word),
      .cnt    (cnt[i])
    );
  end

  assign hb_dout  = dout_q;
  assign hb_oe    = hb_sel & hb_rd;
  assign hb_rdy   = (st_q == HS_RDY);
  assign rst_ctrl = rstc_q;
  assign rp_idx   = idx_q;
  assign rp_we    = rp_we_q;
  assign rp_wdata = rp_wdata_q;
endmodule

// File: rtl/ebb_byte_bridge_chk.sv
module ebb_byte_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hb_sel,
  input logic        hb_rd,
  input logic        hb_wr,
  input logic [2:0]  hb_addr,
  input logic        hb_rdy,
  input logic        rp_we,
  input logic [7:0]  rp_idx,
  input logic [31:0] rst_ctrl
);
  // R1: ready is low whenever reset is applied
  always @(posedge clk) begin
    p_rdy_in_reset_r1: assert (rst_n || !hb_rdy)
      else $error("ready high during reset");
  end

  // R2: ready rises only after a strobe held for three edges
  p_rdy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_rdy) |-> $past(hb_sel && (hb_rd || hb_wr), 3));

  // R2: ready falls only after the strobe has been gone two edges
  p_rdy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_rdy) |-> $past(!(hb_sel && (hb_rd || hb_wr)), 2));

  // R4: reset-control changes only on a held lane-3 data write
  p_rstc_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rst_ctrl) |-> $past(hb_sel && hb_wr && hb_addr == 3'b111));

  // R12: one pulse per access
  p_we_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rp_we |=> !rp_we);

  // R10: local indices never reach the external port
  p_ext_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rp_we |-> rp_idx >= 8'd5);
endmodule

bind ebb_byte_bridge ebb_byte_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_rd(hb_rd), .hb_wr(hb_wr),
  .hb_addr(hb_addr), .hb_rdy(hb_rdy), .rp_we(rp_we), .rp_idx(rp_idx),
  .rst_ctrl(rst_ctrl)
);

// File: tb/ebb_byte_bridge_tb.sv
module ebb_byte_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 8;
  localparam logic [31:0] ID_EXP = 32'h1F3A_2123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_sel = 1'b0, hb_rd = 1'b0, hb_wr = 1'b0;
  logic [2:0] hb_addr = '0;
  logic [7:0] hb_din = '0;
  logic [7:0] hb_dout;
  logic hb_oe, hb_rdy, rp_we;
  logic [31:0] rst_ctrl, rp_wdata, rp_rdata;
  logic [NEV-1:0] evt = '0;
  logic [7:0] rp_idx;
  logic [31:0] ext_mem [256];

  int n_run = 0, n_fail = 0, we_cnt = 0;
  int last_up = 0, last_dn = 0;
  logic oe_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebb_byte_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_rd(hb_rd), .hb_wr(hb_wr),
    .hb_addr(hb_addr), .hb_din(hb_din), .hb_dout(hb_dout), .hb_oe(hb_oe),
    .hb_rdy(hb_rdy), .rst_ctrl(rst_ctrl), .evt(evt), .rp_idx(rp_idx),
    .rp_we(rp_we), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata)
  );

  assign rp_rdata = ext_mem[rp_idx];
  always @(posedge clk) begin
    if (rp_we) begin
      ext_mem[rp_idx] <= rp_wdata;
      we_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // one bus access; records edge counts for ready rise and fall
  task automatic access(input logic is_rd, input logic [2:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    int n;
    @(negedge clk);
    hb_addr = a; hb_din = d; hb_sel = 1'b1;
    if (is_rd) hb_rd = 1'b1; else hb_wr = 1'b1;
    n = 0;
    oe_seen = 1'b0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (hb_oe) oe_seen = 1'b1;
    end while (!hb_rdy && n < 30);
    last_up = n;
    q = hb_dout;
    hb_sel = 1'b0; hb_rd = 1'b0; hb_wr = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (hb_rdy && n < 30);
    last_dn = n;
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    access(1'b0, a, d, q);
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] q);
    access(1'b1, a, 8'h00, q);
  endtask

  task automatic set_idx(input logic [7:0] i);
    wr_byte(3'b000, i);
  endtask

  task automatic wr_word(input logic [7:0] i, input logic [31:0] w);
    set_idx(i);
    for (int k = 0; k < 4; k++) wr_byte({1'b1, 2'(k)}, w[8*k +: 8]);
  endtask

  task automatic rd_word(input logic [7:0] i, output logic [31:0] w);
    logic [7:0] q;
    set_idx(i);
    for (int k = 0; k < 4; k++) begin
      rd_byte({1'b1, 2'(k)}, q);
      w[8*k +: 8] = q;
    end
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 rdy", {31'd0, hb_rdy}, 32'd0);
    chk("R1 oe", {31'd0, hb_oe}, 32'd0);
    chk("R1 rst_ctrl", rst_ctrl, 32'd0);
    chk("R1 rp_we", {31'd0, rp_we}, 32'd0);
    rd_byte(3'b000, q);
    chk("R1 index", {24'd0, q}, 32'd0);
  endtask

  task automatic t_handshake();
    set_idx(8'h01);
    chk("R2 edges to ready", last_up, 4);
    chk("R2 edges to release", last_dn, 3);
    chk("R11 oe during write", {31'd0, oe_seen}, 32'd0);
  endtask

  task automatic t_index();
    logic [7:0] q;
    set_idx(8'h37);
    rd_byte(3'b000, q);
    chk("R3 index readback", {24'd0, q}, 32'h37);
    chk("R11 oe during read", {31'd0, oe_seen}, 32'd1);
    rd_byte(3'b011, q);
    chk("R3 lane bits ignored", {24'd0, q}, 32'h37);
  endtask

  task automatic t_pack();
    logic [31:0] w;
    set_idx(8'h01);
    wr_byte(3'b100, 8'hAA);
    wr_byte(3'b101, 8'hBB);
    wr_byte(3'b110, 8'hCC);
    chk("R4 staged not committed", rst_ctrl, 32'd0);
    wr_byte(3'b111, 8'hDD);
    chk("R4 R7 commit on lane3", rst_ctrl, 32'hDDCC_BBAA);
    rd_word(8'h01, w);
    chk("R7 readback", w, 32'hDDCC_BBAA);
  endtask

  task automatic t_snapshot();
    logic [7:0] q;
    set_idx(8'h01);
    rd_byte(3'b100, q);
    chk("R5 lane0 live", {24'd0, q}, 32'hAA);
    for (int k = 0; k < 4; k++) wr_byte({1'b1, 2'(k)}, 8'h11 * 8'(k + 1));
    chk("R7 new word", rst_ctrl, 32'h4433_2211);
    rd_byte(3'b101, q);
    chk("R5 lane1 from capture", {24'd0, q}, 32'hBB);
    rd_byte(3'b110, q);
    chk("R5 lane2 from capture", {24'd0, q}, 32'hCC);
    rd_byte(3'b111, q);
    chk("R5 lane3 from capture", {24'd0, q}, 32'hDD);
  endtask

  task automatic t_id();
    logic [31:0] w;
    int we0;
    we0 = we_cnt;
    rd_word(8'h00, w);
    chk("R6 id word", w, ID_EXP);
    wr_word(8'h00, 32'hFFFF_FFFF);
    rd_word(8'h00, w);
    chk("R10 id unchanged", w, ID_EXP);
    chk("R10 no ext write", we_cnt - we0, 0);
  endtask

  task automatic t_perf();
    logic [31:0] w;
    wr_word(8'h03, 32'h0);
    wr_word(8'h04, 32'h100);
    wr_word(8'h02, 32'h0000_8685);
    @(negedge clk);
    evt[5] = 1'b1; evt[6] = 1'b1; evt[1] = 1'b1;
    repeat (3) @(negedge clk);
    evt[6] = 1'b0;
    repeat (4) @(negedge clk);
    evt[5] = 1'b0; evt[1] = 1'b0;
    rd_word(8'h03, w);
    chk("R8 counter0", w, 32'd7);
    rd_word(8'h04, w);
    chk("R8 counter1", w, 32'h103);
    wr_word(8'h02, 32'h0000_0005);
    @(negedge clk);
    evt[5] = 1'b1;
    repeat (5) @(negedge clk);
    evt[5] = 1'b0;
    rd_word(8'h03, w);
    chk("R8 disabled holds", w, 32'd7);
  endtask

  task automatic t_ext();
    logic [31:0] w;
    int we0;
    we0 = we_cnt;
    wr_word(8'h40, 32'hCAFE_F00D);
    chk("R9 R12 one pulse", we_cnt - we0, 1);
    chk("R9 ext stored", ext_mem[8'h40], 32'hCAFE_F00D);
    rd_word(8'h40, w);
    chk("R9 ext readback", w, 32'hCAFE_F00D);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) ext_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_handshake();
    t_index();
    t_pack();
    t_snapshot();
    t_id();
    t_perf();
    t_ext();
    finish_run();
  end
endmodule